// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Registers

This block is the register-level interrupt hub of a chipset that serves up to four processors. It holds one 64-bit device-interrupt enable mask for each processor. It samples a 64-bit vector of raw device requests every cycle. From these it drives one device-interrupt line per processor, which is high while that processor's masked vector is nonzero. It also keeps two pending vectors, one bit per processor. One is for inter-processor interrupts (IPIs) and one is for interval-timer interrupts. Each pending bit drives its own output line.

Software reaches the block through a simple request port. A request is one cycle with a valid strobe, a write flag, a byte address, an access size in bytes, 64 bits of write data and the number of the requesting processor. Every request gets a response one cycle later, carrying read data and an error flag. The register number is the byte offset shifted right by six, so each register occupies a 64-byte slot. The map uses these register numbers:

| Number | Register |
|---|---|
| 0 | Combined control word |
| 1 | Raw request vector |
| 2 | IPI status |
| 3 | Timer status |
| 4 | IPI request |
| 8+c | Mask of processor c |
| 12+c | Masked vector of processor c |

A timer tick input marks a timer interrupt pending on every processor.

Top module: `mp_irq_csr`

## Requirements
- R1: After reset every mask, the sampled raw vector and both pending vectors are zero. All interrupt lines and response outputs are low.
- R2: The register number is address bits [ADDR_W-1:6]. Address bits 5:0 do not change which register a request reaches.
- R3: A request whose size is not 8 bytes gets rsp_err set and read data zero, and changes no state.
- R4: Register 8+c holds the mask of processor c and reads it back. Register 12+c reads that mask ANDed with the sampled raw vector. Register 1 reads the sampled raw vector. raw_irq_in is captured into that vector on every clock.
- R5: dev_irq[c] is high exactly when mask c AND the sampled raw vector is nonzero. The line follows a mask write on the next edge and follows a raw_irq_in change one edge after the capture.
- R6: In a write to register 0, a set bit 12+c posts an IPI to processor c. A processor whose IPI is already pending stays pending.
- R7: In a write to register 0, a set bit 8+c clears processor c's pending IPI. When a write both posts and clears the same processor, the clear wins.
- R8: In a write to register 0, a set bit 4+c clears processor c's pending timer interrupt.
- R9: A write to register 0 whose bits 15:4 are zero and whose bit 28 is set is accepted without error and has no effect. One with bits 15:4 and bit 28 all zero sets rsp_err and has no effect.
- R10: timer_tick sets every processor's timer pending bit on the next edge. A tick wins over a timer clear in the same cycle.
- R11: Registers 2 and 3 read the IPI and timer pending vectors in bits 3:0. A write to either clears the processors whose bits are set. A write to register 4 posts IPIs to the processors set in bits 3:0.
- R12: A read of register 0 returns the IPI pending vector in bits 11:8, the timer pending vector in bits 7:4 and req_cpu in bits 1:0. All other bits read zero.
- R13: A read of an unmapped register or of register 4 returns zero with rsp_err. A write to registers 1, 12+c or an unmapped register is ignored and sets rsp_err.
- R14: rsp_valid is high exactly one cycle after each accepted request strobe. rsp_rdata and rsp_err are valid in that cycle and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset from the block base |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| req_cpu | input | 2 | Number of the requesting processor |
| raw_irq_in | input | 64 | Raw device request vector |
| timer_tick | input | 1 | Interval timer tick |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Access error |
| dev_irq | output | NCPU | Per-processor device interrupt |
| ipi_irq | output | NCPU | Per-processor IPI pending |
| tmr_irq | output | NCPU | Per-processor timer pending |

## Verification
The bench sends posts and clears for the same processor in a single control-word write. A design that applied them in the opposite order would leave the IPI pending. It also raises a tick in the same cycle as a timer clear, which a design that let the clear win would lose. Control-word writes carrying only bit 28, or nothing at all, separate the accepted no-op from the error case. Accesses of the wrong size, writes to read-only slots and address offsets inside a slot expose loose decoding. Raw-vector changes with no mask write catch a design that recomputes the device lines only on mask writes.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  typedef enum logic [2:0] {
    K_CTRL, K_RAW, K_IPI_STAT, K_TMR_STAT, K_IPI_REQ, K_MASK, K_MVEC, K_NONE
  } reg_kind_e;

  localparam int unsigned IDX_CTRL     = 0;
  localparam int unsigned IDX_RAW      = 1;
  localparam int unsigned IDX_IPI_STAT = 2;
  localparam int unsigned IDX_TMR_STAT = 3;
  localparam int unsigned IDX_IPI_REQ  = 4;
  localparam int unsigned IDX_MASK     = 8;
  localparam int unsigned IDX_MVEC     = 12;
  localparam int unsigned SLOT_SHIFT   = 6;
  localparam int unsigned LEGAL_SIZE   = 8;
endpackage

// File: rtl/icsr_decode.sv
module icsr_decode
  import icsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NCPU   = 4,
  localparam int unsigned CW    = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output reg_kind_e         kind,
  output logic [CW-1:0]     cpu_sel,
  output logic              size_ok
);
  localparam int unsigned IW = ADDR_W - SLOT_SHIFT;

  logic [IW-1:0] idx;
  logic [IW-1:0] sub;

  assign idx     = addr[ADDR_W-1:SLOT_SHIFT];
  assign size_ok = (size == 4'(LEGAL_SIZE));
  assign sub     = idx & IW'(3);
  assign cpu_sel = CW'(sub);

  always_comb begin
    kind = K_NONE;
    if (idx == IW'(IDX_CTRL))          kind = K_CTRL;
    else if (idx == IW'(IDX_RAW))      kind = K_RAW;
    else if (idx == IW'(IDX_IPI_STAT)) kind = K_IPI_STAT;
    else if (idx == IW'(IDX_TMR_STAT)) kind = K_TMR_STAT;
    else if (idx == IW'(IDX_IPI_REQ))  kind = K_IPI_REQ;
    else if ((idx & ~IW'(3)) == IW'(IDX_MASK) && sub < IW'(NCPU)) kind = K_MASK;
    else if ((idx & ~IW'(3)) == IW'(IDX_MVEC) && sub < IW'(NCPU)) kind = K_MVEC;
  end
endmodule

// File: rtl/icsr_pend.sv
module icsr_pend #(
  parameter int unsigned N        = 4,
  parameter bit          SET_WINS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] q
);
  logic [N-1:0] q_nxt;
  logic         upd_en;

  generate
    if (SET_WINS) begin : g_set_wins
      assign q_nxt = (q & ~clr_vec) | set_vec;
    end else begin : g_clr_wins
      assign q_nxt = (q | set_vec) & ~clr_vec;
    end
  endgenerate

  assign upd_en = |(set_vec | clr_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (upd_en) q <= q_nxt;
  end
endmodule

// File: rtl/icsr_mask_bank.sv
module icsr_mask_bank #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned DW   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCPU-1:0]           wr_en,
  input  logic [DW-1:0]             wdata,
  input  logic [DW-1:0]             raw_q,
  output logic [NCPU-1:0][DW-1:0]   mask_q,
  output logic [NCPU-1:0][DW-1:0]   mvec,
  output logic [NCPU-1:0]           dev_irq
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q[c] <= '0;
      else if (wr_en[c]) mask_q[c] <= wdata;
    end
    assign mvec[c]    = mask_q[c] & raw_q;
    assign dev_irq[c] = |mvec[c];
  end
endmodule

// File: rtl/mp_irq_csr.sv
module mp_irq_csr
  import icsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NCPU   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [1:0]        req_cpu,
  input  logic [63:0]       raw_irq_in,
  input  logic              timer_tick,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NCPU-1:0]   dev_irq,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  localparam int unsigned DW = 64;
  localparam int unsigned CW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int unsigned POST_LSB = 12;
  localparam int unsigned ICLR_LSB = 8;
  localparam int unsigned TCLR_LSB = 4;
  localparam int unsigned NOP_BIT  = 28;

  reg_kind_e             kind;
  logic [CW-1:0]         cpu_sel;
  logic                  size_ok;
  logic [DW-1:0]         raw_q;
  logic [NCPU-1:0][DW-1:0] mask_q;
  logic [NCPU-1:0][DW-1:0] mvec;
  logic [NCPU-1:0]       mask_we;
  logic                  acc_wr, acc_rd, ctrl_wr, ctrl_empty;
  logic [NCPU-1:0]       ipi_set, ipi_clr, tmr_set, tmr_clr;
  logic                  err_nxt;
  logic [DW-1:0]         rdata_nxt;

  icsr_decode #(.ADDR_W(ADDR_W), .NCPU(NCPU)) u_dec (
    .addr(req_addr), .size(req_size),
    .kind(kind), .cpu_sel(cpu_sel), .size_ok(size_ok)
  );

  assign acc_wr = req_valid && size_ok && req_write;
  assign acc_rd = req_valid && size_ok && !req_write;
  assign ctrl_wr = acc_wr && (kind == K_CTRL);
  assign ctrl_empty = (req_wdata[15:4] == '0) && !req_wdata[NOP_BIT];

  for (genvar c = 0; c < NCPU; c++) begin : g_we
    assign mask_we[c] = acc_wr && (kind == K_MASK) && (cpu_sel == CW'(c));
  end

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    if (ctrl_wr) begin
      ipi_set = req_wdata[POST_LSB +: NCPU];
      ipi_clr = req_wdata[ICLR_LSB +: NCPU];
      tmr_clr = req_wdata[TCLR_LSB +: NCPU];
    end
    if (acc_wr && kind == K_IPI_REQ)  ipi_set = req_wdata[NCPU-1:0];
    if (acc_wr && kind == K_IPI_STAT) ipi_clr = req_wdata[NCPU-1:0];
    if (acc_wr && kind == K_TMR_STAT) tmr_clr = req_wdata[NCPU-1:0];
  end

  assign tmr_set = timer_tick ? '1 : '0;

  icsr_pend #(.N(NCPU), .SET_WINS(1'b0)) u_ipi (
    .clk(clk), .rst_n(rst_n), .set_vec(ipi_set), .clr_vec(ipi_clr), .q(ipi_irq)
  );

  icsr_pend #(.N(NCPU), .SET_WINS(1'b1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .set_vec(tmr_set), .clr_vec(tmr_clr), .q(tmr_irq)
  );

  icsr_mask_bank #(.NCPU(NCPU), .DW(DW)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_we), .wdata(req_wdata),
    .raw_q(raw_q), .mask_q(mask_q), .mvec(mvec), .dev_irq(dev_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_irq_in;
  end

  always_comb begin
    err_nxt = 1'b0;
    if (req_valid) begin
      if (!size_ok) err_nxt = 1'b1;
      else if (req_write)
        err_nxt = (kind == K_RAW) || (kind == K_MVEC) || (kind == K_NONE) ||
                  ((kind == K_CTRL) && ctrl_empty);
      else
        err_nxt = (kind == K_NONE) || (kind == K_IPI_REQ);
    end
  end

  always_comb begin
    rdata_nxt = '0;
    if (acc_rd) begin
      case (kind)
        K_CTRL: begin
          rdata_nxt[ICLR_LSB +: NCPU] = ipi_irq;
          rdata_nxt[TCLR_LSB +: NCPU] = tmr_irq;
          rdata_nxt[1:0]              = req_cpu;
        end
        K_RAW:      rdata_nxt = raw_q;
        K_IPI_STAT: rdata_nxt[NCPU-1:0] = ipi_irq;
        K_TMR_STAT: rdata_nxt[NCPU-1:0] = tmr_irq;
        K_MASK:     rdata_nxt = mask_q[cpu_sel];
        K_MVEC:     rdata_nxt = mvec[cpu_sel];
        default:    rdata_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err_nxt;
      rsp_rdata <= rdata_nxt;
    end
  end
endmodule

// File: rtl/icsr_checker.sv
module icsr_checker #(
  parameter int unsigned NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [3:0]      req_size,
  input logic [63:0]     raw_irq_in,
  input logic            timer_tick,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [63:0]     rsp_rdata,
  input logic [NCPU-1:0] dev_irq,
  input logic [NCPU-1:0] ipi_irq,
  input logic [NCPU-1:0] tmr_irq
);
  p_size_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd8) |=> (rsp_err && rsp_rdata == '0));

  p_rsp_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));

  p_dev_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_irq_in) == '0) |-> (dev_irq == '0));

  p_tick_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timer_tick |=> (&tmr_irq));

  p_tmr_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_irq & ~$past(tmr_irq)) != '0) |-> $past(timer_tick));

  p_ipi_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_irq & ~$past(ipi_irq)) != '0) |-> $past(req_valid && req_write));

  p_ipi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write) |-> ((ipi_irq & $past(ipi_irq)) == $past(ipi_irq)));
endmodule

bind mp_irq_csr icsr_checker #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .raw_irq_in(raw_irq_in), .timer_tick(timer_tick),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .dev_irq(dev_irq), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
);

// File: tb/mp_irq_csr_test.sv
module mp_irq_csr_test;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NCPU   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [3:0]        req_size;
  logic [63:0]       req_wdata;
  logic [1:0]        req_cpu;
  logic [63:0]       raw_irq_in;
  logic              timer_tick;
  logic              rsp_valid, rsp_err;
  logic [63:0]       rsp_rdata;
  logic [NCPU-1:0]   dev_irq, ipi_irq, tmr_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] got_d;
  logic        got_e, got_v;

  always #5 clk = ~clk;

  mp_irq_csr #(.ADDR_W(ADDR_W), .NCPU(NCPU)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_cpu(req_cpu), .raw_irq_in(raw_irq_in), .timer_tick(timer_tick),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dev_irq(dev_irq), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] slot(input int n);
    return ADDR_W'(n << 6);
  endfunction

  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [3:0] sz,
                        input logic [63:0] d, input logic [1:0] cpu);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = d; req_cpu = cpu;
    @(negedge clk);
    got_v = rsp_valid; got_d = rsp_rdata; got_e = rsp_err;
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic wr64(input int n, input logic [63:0] d);
    access(1'b1, slot(n), 4'd8, d, 2'd0);
  endtask

  task automatic rd64(input int n);
    access(1'b0, slot(n), 4'd8, 64'd0, 2'd0);
  endtask

  task automatic t_reset;
    check("R1 dev", 64'(dev_irq), 0);
    check("R1 ipi", 64'(ipi_irq), 0);
    check("R1 tmr", 64'(tmr_irq), 0);
    check("R1 rsp", {62'd0, rsp_valid, rsp_err}, 0);
    rd64(9); check("R1 mask1", got_d, 0);
  endtask

  task automatic t_mask_dev;
    @(negedge clk); raw_irq_in = 64'h30;
    wr64(8, 64'hF0);
    check("R5 dev after mask0", 64'(dev_irq), 64'h1);
    wr64(9, 64'h0F);
    check("R5 dev after mask1", 64'(dev_irq), 64'h1);
    rd64(12); check("R4 mvec0", got_d, 64'h30);
    rd64(8);  check("R4 mask0", got_d, 64'hF0);
    rd64(1);  check("R4 raw", got_d, 64'h30);
    check("R14 valid", 64'(got_v), 1);
    @(negedge clk); raw_irq_in = 64'h0C;
    @(negedge clk);
    check("R5 dev after raw change", 64'(dev_irq), 64'h2);
    rd64(13); check("R4 mvec1", got_d, 64'h0C);
    @(negedge clk); raw_irq_in = 64'h0;
    @(negedge clk);
    check("R5 dev raw zero", 64'(dev_irq), 0);
  endtask

  task automatic t_alias;
    access(1'b0, slot(8) | ADDR_W'(6'h28), 4'd8, 0, 2'd0);
    check("R2 offset alias", got_d, 64'hF0);
    check("R2 no err", 64'(got_e), 0);
  endtask

  task automatic t_ctrl_ipi;
    wr64(0, 64'h5000);
    check("R6 post", 64'(ipi_irq), 64'h5);
    wr64(0, 64'h1000);
    check("R6 already pending", 64'(ipi_irq), 64'h5);
    wr64(0, 64'h0400);
    check("R7 clear", 64'(ipi_irq), 64'h1);
    wr64(0, 64'h2200);
    check("R7 clear wins", 64'(ipi_irq), 64'h1);
    check("R7 no err", 64'(got_e), 0);
  endtask

  task automatic t_timer;
    @(negedge clk); timer_tick = 1'b1;
    @(negedge clk); timer_tick = 1'b0;
    check("R10 tick", 64'(tmr_irq), 64'hF);
    wr64(0, 64'h0060);
    check("R8 timer clear", 64'(tmr_irq), 64'h9);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = slot(0); req_size = 4'd8;
    req_wdata = 64'h00F0; timer_tick = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; timer_tick = 1'b0;
    check("R10 tick wins", 64'(tmr_irq), 64'hF);
  endtask

  task automatic t_nop;
    wr64(0, 64'h1000_0000);
    check("R9 nop no err", 64'(got_e), 0);
    check("R9 nop ipi", 64'(ipi_irq), 64'h1);
    check("R9 nop tmr", 64'(tmr_irq), 64'hF);
    wr64(0, 64'h0000_000F);
    check("R9 empty err", 64'(got_e), 1);
    check("R9 empty ipi", 64'(ipi_irq), 64'h1);
  endtask

  task automatic t_ctrl_read;
    access(1'b0, slot(0), 4'd8, 0, 2'd3);
    check("R12 ctrl read", got_d, 64'h0000_01F3);
  endtask

  task automatic t_status;
    rd64(2); check("R11 ipi stat", got_d, 64'h1);
    rd64(3); check("R11 tmr stat", got_d, 64'hF);
    wr64(4, 64'hA);
    check("R11 ipi req", 64'(ipi_irq), 64'hB);
    wr64(2, 64'h3);
    check("R11 ipi stat clr", 64'(ipi_irq), 64'h8);
    wr64(3, 64'h5);
    check("R11 tmr stat clr", 64'(tmr_irq), 64'hA);
  endtask

  task automatic t_errors;
    access(1'b1, slot(8), 4'd4, 64'hFFFF, 2'd0);
    check("R3 size err", 64'(got_e), 1);
    rd64(8); check("R3 mask kept", got_d, 64'hF0);
    access(1'b0, slot(8), 4'd2, 0, 2'd0);
    check("R3 size rdata", got_d, 0);
    rd64(5); check("R13 unmapped rd err", 64'(got_e), 1);
    check("R13 unmapped rd data", got_d, 0);
    rd64(4); check("R13 req rd err", 64'(got_e), 1);
    wr64(12, 64'hFF); check("R13 mvec wr err", 64'(got_e), 1);
    wr64(1, 64'hFF);  check("R13 raw wr err", 64'(got_e), 1);
    @(negedge clk); raw_irq_in = 64'h30;
    @(negedge clk);
    rd64(12); check("R13 mvec unchanged", got_d, 64'h30);
    rd64(8);  check("R13 no err good rd", 64'(got_e), 0);
    @(negedge clk);
    check("R14 idle", {62'd0, rsp_valid, rsp_err}, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 4'd8; req_wdata = '0; req_cpu = '0; raw_irq_in = '0;
    timer_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask_dev;
    t_alias;
    t_ctrl_ipi;
    t_timer;
    t_nop;
    t_ctrl_read;
    t_status;
    t_errors;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule